// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. Eleven request sources are split into six priority groups. Each group gets one of four priority levels. The 2-bit level of group g is formed from bit g of a high-level register and bit g of a low-level register. Hardware events set a pending flag for each source. The block gates the flags with per-source enables and a global enable. It then picks the strongest request and presents a registered vector index together with a request line to the CPU.

When the CPU acknowledges a vector, the block clears that source's flag, except for the shared peripheral source. It also pushes the group's level onto a four-entry stack of active levels. A return-from-interrupt pulse pops the stack. A new request is offered only if its level is strictly above the level on top of the stack, which gives nesting by level.

The shared source (vector 10) is the OR of two peripheral events: a transfer-busy event and a one-second tick. Each event has its own sticky flag and its own enable. Only explicit clear pulses from software reset these flags.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req is 0, every pending flag is 0, both peripheral flags are 0 and act_depth is 0.
- R2: Group g's level is {prio_hi[g], prio_lo[g]}: 0 is the lowest and 3 the highest. Vector v (0..9) belongs to group v/2, and vector 10 belongs to group 5. Among enabled pending requests, the one with the highest level is presented. prio_lo bits 7:6 and prio_hi bits 7:6 never change the result.
- R3: When several enabled pending requests share the highest level, the lowest vector index wins. This polls group 0 first through group 5 last, and the lower source before the higher one inside a group.
- R4: A pending source is presented only when its src_en bit and glob_en are both 1. While it is masked, its flag stays visible on pend.
- R5: A pulse on src_ev[v] sets flag v (v = 0..9). An acknowledge while vector v is presented clears it. An event that arrives in the same cycle as that clear leaves the flag set.
- R6: pend[10] is (xfer_flag & xfer_en) | (tick_flag & tick_en). xfer_flag and tick_flag are set by xfer_ev and tick_ev. They are cleared only by xfer_clr and tick_clr, never by an acknowledge.
- R7: irq_req and irq_vec are registered. A flag set at one clock edge is presented after the following edge. irq_req is 0 in the cycle after an accepted acknowledge.
- R8: While act_depth is nonzero, a request is presented only if its level is strictly greater than act_lvl.
- R9: An accepted acknowledge pushes the presented vector's group level, so act_depth rises by one and act_lvl becomes that level. irq_reti pops one entry. The stack holds up to four levels, and act_lvl is 0 when it is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ev | input | 10 | Event pulses for vectors 0..9 |
| src_en | input | 11 | Per-vector enables |
| glob_en | input | 1 | Global interrupt enable |
| prio_lo | input | 8 | Low level bit per group (bits 5:0 used) |
| prio_hi | input | 8 | High level bit per group (bits 5:0 used) |
| xfer_ev | input | 1 | Transfer-busy event pulse |
| tick_ev | input | 1 | One-second tick event pulse |
| xfer_en | input | 1 | Enable of transfer-busy into vector 10 |
| tick_en | input | 1 | Enable of tick into vector 10 |
| xfer_clr | input | 1 | Software clear of xfer_flag |
| tick_clr | input | 1 | Software clear of tick_flag |
| xfer_flag | output | 1 | Sticky transfer-busy flag |
| tick_flag | output | 1 | Sticky tick flag |
| pend | output | 11 | Pending flags per vector |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 4 | Presented vector index |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| act_lvl | output | 2 | Level on top of the active stack |
| act_depth | output | 3 | Number of active nested levels |

## Verification
The sweep draws random level settings, including the unused register bits, and random sets of pending sources. It then drains each set one acknowledge at a time and compares every presented vector with a model that picks the highest level and the lowest index. A wrong level encoding or a reversed polling order would show up as an out-of-order vector. Directed cases cover four points:
- An event arriving together with its own acknowledge: a lost edge would leave the flag clear.
- The shared peripheral source surviving an acknowledge: an auto-clear would drop the tick flag.
- Equal-level requests during service: non-strict preemption would present them too early.
- A four-deep nest unwound by return pulses: a broken stack would report the wrong active level.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NGRP = 6,
  parameter int NSRC = 11,
  parameter int NSTK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-2:0]          src_ev,
  input  logic [NSRC-1:0]          src_en,
  input  logic                     glob_en,
  input  logic [7:0]               prio_lo,
  input  logic [7:0]               prio_hi,
  input  logic                     xfer_ev,
  input  logic                     tick_ev,
  input  logic                     xfer_en,
  input  logic                     tick_en,
  input  logic                     xfer_clr,
  input  logic                     tick_clr,
  output logic                     xfer_flag,
  output logic                     tick_flag,
  output logic [NSRC-1:0]          pend,
  output logic                     irq_req,
  output logic [$clog2(NSRC)-1:0]  irq_vec,
  input  logic                     irq_ack,
  input  logic                     irq_reti,
  output logic [1:0]               act_lvl,
  output logic [$clog2(NSTK+1)-1:0] act_depth
);
  localparam int NHW = NSRC - 1;
  localparam int VW  = $clog2(NSRC);
  localparam int DW  = $clog2(NSTK + 1);
  localparam int SW  = $clog2(NSTK);

  logic [NHW-1:0] hw_flag;
  logic [1:0]     stk [NSTK];
  logic [VW-1:0]  win;
  logic [1:0]     best, top;
  logic           found, grant, ack_ok;
  logic [NSRC-1:0] clr_mask;
  logic [DW-1:0]  tdx;

  wire unused_prio = ^{prio_lo[7:NGRP], prio_hi[7:NGRP]};

  function automatic logic [1:0] lvl_of(input int v);
    int g;
    g = (v >= NHW) ? NGRP - 1 : v / 2;
    return {prio_hi[g], prio_lo[g]};
  endfunction

  assign pend     = {(xfer_flag & xfer_en) | (tick_flag & tick_en), hw_flag};
  assign ack_ok   = irq_ack & irq_req;
  assign clr_mask = ack_ok ? (NSRC'(1) << irq_vec) : '0;
  assign tdx      = act_depth - 1'b1;
  assign top      = (act_depth == 0) ? 2'd0 : stk[tdx[SW-1:0]];
  assign act_lvl  = top;
  assign grant    = found && (act_depth == 0 || best > top);

  always_comb begin
    found = 1'b0;
    best  = 2'd0;
    win   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && src_en[i] && glob_en && (!found || lvl_of(i) >= best)) begin
        found = 1'b1;
        best  = lvl_of(i);
        win   = VW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_flag   <= '0;
      xfer_flag <= 1'b0;
      tick_flag <= 1'b0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      act_depth <= '0;
      for (int k = 0; k < NSTK; k++) stk[k] <= 2'd0;
    end else begin
      hw_flag   <= (hw_flag & ~clr_mask[NHW-1:0]) | src_ev;
      xfer_flag <= (xfer_flag & ~xfer_clr) | xfer_ev;
      tick_flag <= (tick_flag & ~tick_clr) | tick_ev;
      irq_req   <= grant & ~ack_ok;
      irq_vec   <= win;
      if (ack_ok && act_depth < DW'(NSTK)) begin
        stk[act_depth[SW-1:0]] <= lvl_of(int'(irq_vec));
        act_depth <= act_depth + 1'b1;
      end else if (irq_reti && act_depth != 0) begin
        act_depth <= act_depth - 1'b1;
      end
    end
  end
endmodule

module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  src_ev,
  input logic        glob_en,
  input logic        xfer_flag,
  input logic        xfer_clr,
  input logic [10:0] pend,
  input logic        irq_req,
  input logic [3:0]  irq_vec,
  input logic        irq_ack,
  input logic        irq_reti,
  input logic [2:0]  act_depth
);
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req |=> !irq_req);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req && irq_vec < 4'd10 && !src_ev[irq_vec] |=> !pend[$past(irq_vec)]);

  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req && act_depth < 3'd4 |=> act_depth == $past(act_depth) + 3'd1);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth <= 3'd4);

  p_glob_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq_req);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_flag && !xfer_clr |=> xfer_flag);

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reti && !irq_ack && act_depth != 3'd0 |=> act_depth == $past(act_depth) - 3'd1);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [9:0] src_ev = 0;
  logic [10:0] src_en = 0;
  logic glob_en = 0;
  logic [7:0] prio_lo = 0, prio_hi = 0;
  logic xfer_ev = 0, tick_ev = 0, xfer_en = 0, tick_en = 0, xfer_clr = 0, tick_clr = 0;
  logic xfer_flag, tick_flag, irq_req, irq_ack = 0, irq_reti = 0;
  logic [10:0] pend;
  logic [3:0] irq_vec;
  logic [1:0] act_lvl;
  logic [2:0] act_depth;
  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  irq_prio_ctrl u_irq_prio_ctrl (.*);

  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse(input int v);
    if (v == 10) xfer_ev = 1; else src_ev[v] = 1;
    tick(1);
    src_ev = 0; xfer_ev = 0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(1); irq_ack = 0; tick(3);
  endtask

  task automatic reti();
    irq_reti = 1; tick(1); irq_reti = 0; tick(3);
  endtask

  function automatic logic [1:0] lvl(input int i, input logic [7:0] lo, input logic [7:0] hi);
    int g;
    g = (i >= 10) ? 5 : i / 2;
    return {hi[g], lo[g]};
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    check("R1 req", irq_req, 0);
    check("R1 pend", pend, 0);
    check("R1 flags", {xfer_flag, tick_flag}, 0);
    check("R1 depth", act_depth, 0);

    glob_en = 1; src_en = '1; xfer_en = 1; tick_en = 1;

    // R7 registered timing and drop after ack, R5 clear
    src_ev[4] = 1; tick(1); src_ev = 0;
    check("R7 flag set", pend[4], 1);
    check("R7 req not yet", irq_req, 0);
    tick(1);
    check("R7 req", irq_req, 1);
    check("R7 vec", irq_vec, 4);
    irq_ack = 1; tick(1); irq_ack = 0;
    check("R7 drop after ack", irq_req, 0);
    check("R5 cleared", pend[4], 0);
    check("R9 push depth", act_depth, 1);
    reti();
    check("R9 pop depth", act_depth, 0);

    // R4 masking
    src_en[3] = 0; pulse(3); tick(3);
    check("R4 src masked req", irq_req, 0);
    check("R4 flag visible", pend[3], 1);
    src_en = '1; glob_en = 0; tick(3);
    check("R4 glob masked req", irq_req, 0);
    glob_en = 1; tick(3);
    check("R4 unmasked vec", {irq_req, irq_vec}, {1'b1, 4'd3});
    ack(); reti();

    // R5 event in same cycle as clear
    pulse(6); tick(3);
    check("R5 vec", irq_vec, 6);
    irq_ack = 1; src_ev[6] = 1; tick(1); irq_ack = 0; src_ev = 0;
    check("R5 kept pending", pend[6], 1);
    reti();
    check("R5 re-presented", {irq_req, irq_vec}, {1'b1, 4'd6});
    ack(); reti();
    check("R5 finally clear", pend[6], 0);

    // R6 shared peripheral source
    xfer_en = 0;
    pulse(10); tick(3);
    check("R6 xfer flag", xfer_flag, 1);
    check("R6 xfer disabled", pend[10], 0);
    check("R6 no req", irq_req, 0);
    tick_ev = 1; tick(1); tick_ev = 0; tick(3);
    check("R6 tick req", {irq_req, irq_vec}, {1'b1, 4'd10});
    ack(); reti();
    check("R6 tick sticky after ack", tick_flag, 1);
    check("R6 still requesting", {irq_req, irq_vec}, {1'b1, 4'd10});
    tick_clr = 1; tick(1); tick_clr = 0; tick(3);
    check("R6 tick cleared", tick_flag, 0);
    check("R6 xfer untouched", xfer_flag, 1);
    check("R6 pend gone", pend[10], 0);
    xfer_clr = 1; tick(1); xfer_clr = 0; tick(1);
    check("R6 xfer cleared", xfer_flag, 0);
    xfer_en = 1;

    // R8/R9 nesting: g0=0 g1=1 g2=2 g3=3 g4=1
    prio_lo = 8'h1A; prio_hi = 8'h0C;
    pulse(2); tick(3); ack();
    check("R9 lvl after push", act_lvl, 1);
    src_ev[0] = 1; src_ev[8] = 1; tick(1); src_ev = 0; tick(3);
    check("R8 no preempt equal/lower", irq_req, 0);
    pulse(4); tick(3);
    check("R8 preempt higher", {irq_req, irq_vec}, {1'b1, 4'd4});
    ack();
    pulse(6); tick(3);
    check("R8 preempt top", irq_vec, 6);
    ack();
    check("R9 depth 3", act_depth, 3);
    check("R9 lvl 3", act_lvl, 3);
    reti();
    check("R9 lvl 2 after pop", act_lvl, 2);
    check("R8 blocked at 2", irq_req, 0);
    reti();
    check("R8 equal blocked", irq_req, 0);
    reti();
    check("R8 free after unwind", {irq_req, irq_vec}, {1'b1, 4'd8});
    ack(); reti();
    check("R3 remaining", irq_vec, 0);
    ack();
    pulse(2); tick(3); ack();
    pulse(4); tick(3); ack();
    pulse(6); tick(3); ack();
    check("R9 full depth", act_depth, 4);
    check("R9 full lvl", act_lvl, 3);
    reti(); reti(); reti(); reti();
    check("R9 empty", act_depth, 0);
    check("R9 empty lvl", act_lvl, 0);
    check("R9 idle", irq_req, 0);

    // R2/R3 sweep
    for (int t = 0; t < 200; t++) begin
      logic [10:0] rem;
      logic [31:0] r;
      r = rnd(); prio_lo = r[7:0]; prio_hi = r[15:8];
      rem = r[26:16];
      if (rem == 0) rem = 11'd1;
      src_ev = rem[9:0]; xfer_ev = rem[10]; tick(1); src_ev = 0; xfer_ev = 0;
      tick(3);
      while (rem != 0) begin
        int w, ties;
        logic [1:0] bl;
        w = -1; bl = 0; ties = 0;
        for (int i = 0; i < 11; i++)
          if (rem[i] && (w < 0 || lvl(i, prio_lo, prio_hi) > bl)) begin
            w = i; bl = lvl(i, prio_lo, prio_hi);
          end
        for (int i = 0; i < 11; i++)
          if (rem[i] && lvl(i, prio_lo, prio_hi) == bl) ties++;
        check(ties > 1 ? "R3 tie order" : "R2 level order", {irq_req, irq_vec}, {1'b1, 4'(w)});
        irq_ack = 1; tick(1); irq_ack = 0;
        if (w == 10) begin xfer_clr = 1; tick(1); xfer_clr = 0; end
        else tick(1);
        reti();
        rem[w] = 0;
      end
      check("R2 drained", {irq_req, pend}, 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule